// File: doc/BRIEF.md
# Codec Control Serial Frame Writer

This block performs single-register writes into one of two audio codec chips over a three-wire serial control link. The link has a clock line, a data line and two active-low chip selects. A host places a codec index, a 5-bit register address and an 8-bit value on the inputs and pulses `start_i`. The block captures them and assembles a 16-bit write frame. It then shifts the frame out, most significant bit first, on a fixed step schedule.

Timing is set by a step prescaler of `STEP_CYCLES` system clocks. Every bit takes three steps. The frame is wrapped in one idle-high step before it and one after it, and there is a chip-select setup step ahead of the first bit. `busy_o` covers the whole transfer. `done_o` pulses once when the final idle step ends.

Top module: `codec_frame_writer`

## Requirements
- R1: The frame is `{2'b10, 1'b1, reg_addr[4:0], wr_data[7:0]}`. Bits [15:14] carry chip address 2, bit 13 is the write marker, bits [12:8] are the register and bits [7:0] are the data.
- R2: All 16 frame bits are shifted out, bit 15 first and bit 0 last.
- R3: Each bit uses three steps in this order: clock low, data driven, clock high. The data line never changes while a chip select is low and the clock is high, so a receiver samples on the rising clock edge.
- R4: After a start is accepted, clock, data and both chip selects stay high for one step. Then only the addressed chip select goes low, and it is held for one step before the clock first falls.
- R5: A codec index of 0 drives `cs_n_o[0]` low. Any nonzero index drives `cs_n_o[1]` low. The two chip selects are never low together.
- R6: After bit 0, the clock, the data line and both chip selects go high in the same cycle and stay high for one step before the transfer finishes.
- R7: A step lasts `STEP_CYCLES` clocks. `done_o` is high in the 51*`STEP_CYCLES`-th cycle after the clock edge that accepts the start.
- R8: `busy_o` is high from the cycle after acceptance. `done_o` is a single-cycle pulse, and `busy_o` is low in that cycle.
- R9: A start that arrives while busy is ignored: no extra frame is sent and the frame in flight is unchanged. Input changes after acceptance have no effect on the frame.
- R10: Synchronous active-high reset puts the clock, data and both chip selects high and `busy_o` and `done_o` low.
- R11: A start presented in the cycle where `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle |
| codec_sel_i | input | SEL_W | Codec index; 0 selects chip select 0, nonzero selects chip select 1 |
| reg_addr_i | input | REG_W | Codec register address |
| wr_data_i | input | DATA_W | Data byte to write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data, idles high |
| cs_n_o | output | 2 | Active-low chip selects, idle high |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by chaining transfers: each new start is driven in exactly the cycle where `done_o` is high. It then checks that `busy_o` rises on the next cycle and that the receiver sees a second, intact frame. The bench also places a stray start in the middle of a busy transfer, with different inputs. It judges that case by confirming that no extra frame is received, that the in-flight frame is unchanged and that the completion time stays the same.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SEL,
      ST_CLO,
      ST_DAT,
      ST_CHI,
      ST_POST
   } cfw_state_t;
endpackage

// File: rtl/cfw_step_timer.sv
module cfw_step_timer #(
   parameter int STEP_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic run,
   output logic tick
);
   generate
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("STEP_CYCLES must be at least 1");
      end
      if (STEP_CYCLES == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(STEP_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || restart) begin
               cnt <= '0;
            end else if (run) begin
               cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/cfw_frame_pack.sv
module cfw_frame_pack #(
   parameter int CHIP_ADDR_W = 2,
   parameter int CHIP_ADDR   = 2,
   parameter int REG_W       = 5,
   parameter int DATA_W      = 8,
   localparam int FRAME_W    = CHIP_ADDR_W + 1 + REG_W + DATA_W
) (
   input  logic [REG_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [FRAME_W-1:0] frame
);
   generate
      if (CHIP_ADDR >= (1 << CHIP_ADDR_W)) begin : g_bad_addr
         $error("CHIP_ADDR does not fit in CHIP_ADDR_W bits");
      end
   endgenerate
   assign frame = {CHIP_ADDR_W'(CHIP_ADDR), 1'b1, reg_addr, wr_data};
endmodule

// File: rtl/cfw_serial_seq.sv
module cfw_serial_seq
   import cfw_pkg::*;
#(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic               tick,
   input  logic               sel_in,
   input  logic [FRAME_W-1:0] frame_in,
   output logic               accept,
   output logic               busy,
   output logic               done,
   output logic               sclk,
   output logic               sdata,
   output logic [1:0]         cs_n
);
   localparam int IW = $clog2(FRAME_W);
   localparam logic [IW-1:0] TOP_BIT = IW'(FRAME_W - 1);

   cfw_state_t         state;
   logic [FRAME_W-1:0] frame_q;
   logic               sel_q;
   logic [IW-1:0]      bit_idx;
   logic               sdata_q;
   logic               done_q;

   assign accept = start && (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         frame_q <= '0;
         sel_q   <= 1'b0;
         bit_idx <= '0;
         sdata_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state   <= ST_PRE;
            frame_q <= frame_in;
            sel_q   <= sel_in;
         end else if (tick) begin
            unique case (state)
               ST_PRE: state <= ST_SEL;
               ST_SEL: begin
                  state   <= ST_CLO;
                  bit_idx <= TOP_BIT;
               end
               ST_CLO: begin
                  state   <= ST_DAT;
                  sdata_q <= frame_q[bit_idx];
               end
               ST_DAT: state <= ST_CHI;
               ST_CHI: begin
                  if (bit_idx == '0) begin
                     state   <= ST_POST;
                     sdata_q <= 1'b1;
                  end else begin
                     state   <= ST_CLO;
                     bit_idx <= bit_idx - 1'b1;
                  end
               end
               ST_POST: begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   logic selecting;
   assign selecting = (state == ST_SEL) || (state == ST_CLO) ||
                      (state == ST_DAT) || (state == ST_CHI);

   assign busy    = (state != ST_IDLE);
   assign done    = done_q;
   assign sclk    = !((state == ST_CLO) || (state == ST_DAT));
   assign sdata   = sdata_q;
   assign cs_n[0] = !(selecting && !sel_q);
   assign cs_n[1] = !(selecting && sel_q);

   assert_cs_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
      $countones(~cs_n) <= 1);
   assert_data_steady_R3: assert property (@(posedge clk) disable iff (rst)
      (cs_n != 2'b11) && sclk && $past(sclk) |-> $stable(sdata));
   assert_clock_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk) |-> (cs_n != 2'b11));
   assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
      busy && start |=> $stable(frame_q) && $stable(sel_q));
   assert_post_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> sclk && sdata && (cs_n == 2'b11));
endmodule

// File: rtl/codec_frame_writer.sv
module codec_frame_writer #(
   parameter int STEP_CYCLES = 5000,
   parameter int SEL_W       = 2,
   parameter int REG_W       = 5,
   parameter int DATA_W      = 8,
   parameter int CHIP_ADDR_W = 2,
   parameter int CHIP_ADDR   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [SEL_W-1:0]  codec_sel_i,
   input  logic [REG_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic [1:0]        cs_n_o
);
   localparam int FRAME_W = CHIP_ADDR_W + 1 + REG_W + DATA_W;

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("SEL_W must be at least 1");
      end
   endgenerate

   logic [FRAME_W-1:0] frame;
   logic               accept;
   logic               tick;

   cfw_frame_pack #(
      .CHIP_ADDR_W (CHIP_ADDR_W),
      .CHIP_ADDR   (CHIP_ADDR),
      .REG_W       (REG_W),
      .DATA_W      (DATA_W)
   ) pack_i (
      .reg_addr (reg_addr_i),
      .wr_data  (wr_data_i),
      .frame    (frame)
   );

   cfw_step_timer #(
      .STEP_CYCLES (STEP_CYCLES)
   ) timer_i (
      .clk     (clk),
      .rst     (rst),
      .restart (accept),
      .run     (busy_o),
      .tick    (tick)
   );

   cfw_serial_seq #(
      .FRAME_W (FRAME_W)
   ) seq_i (
      .clk      (clk),
      .rst      (rst),
      .start    (start_i),
      .tick     (tick),
      .sel_in   (|codec_sel_i),
      .frame_in (frame),
      .accept   (accept),
      .busy     (busy_o),
      .done     (done_o),
      .sclk     (sclk_o),
      .sdata    (sdata_o),
      .cs_n     (cs_n_o)
   );
endmodule

// File: tb/codec_frame_writer_tb_top.sv
module codec_frame_writer_tb_top;
   localparam int STEP = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_i = 1'b0;
   logic [1:0] codec_sel_i = '0;
   logic [4:0] reg_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic       busy_o, done_o, sclk_o, sdata_o;
   logic [1:0] cs_n_o;

   int n_cmp = 0;
   int n_bad = 0;
   int n_sent = 0;
   int n_seen = 0;
   bit finished = 0;

   logic [16:0] exp_q[$];

   always #10 clk = ~clk;

   codec_frame_writer #(.STEP_CYCLES(STEP)) dut_i (
      .clk(clk), .rst(rst), .start_i(start_i), .codec_sel_i(codec_sel_i),
      .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i), .busy_o(busy_o),
      .done_o(done_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .cs_n_o(cs_n_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: behavioural receiver sampling between clock edges
   logic        p_sclk = 1'b1, p_sdata = 1'b1;
   logic [1:0]  p_cs = 2'b11;
   logic [15:0] rx_word = '0;
   int          rx_bits = 0;
   logic        rx_sel = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         if (cs_n_o != 2'b11) begin
            rx_sel = !cs_n_o[1] ? 1'b1 : 1'b0;
            if (sclk_o && !p_sclk) begin
               rx_word = {rx_word[14:0], sdata_o};
               rx_bits++;
            end
            if (sclk_o && p_sclk && (sdata_o != p_sdata) && (p_cs != 2'b11))
               check(0, "R3 data moved while clock high", sdata_o, p_sdata);
            check(cs_n_o != 2'b00, "R5 both selects low", cs_n_o, 3);
         end
         if (p_cs != 2'b11 && cs_n_o == 2'b11) begin
            n_seen++;
            check(sclk_o && sdata_o, "R6 lines high together", {sclk_o, sdata_o}, 3);
            if (exp_q.size() == 0) begin
               check(0, "R9 unexpected frame", rx_word, 0);
            end else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               check(rx_bits == 16, "R2 bit count", rx_bits, 16);
               check(rx_word == e[15:0], "R1 frame word", rx_word, e[15:0]);
               check(rx_sel == e[16], "R5 chip select used", rx_sel, e[16]);
            end
            rx_bits = 0;
            rx_word = '0;
         end
      end
      p_sclk = sclk_o; p_sdata = sdata_o; p_cs = cs_n_o;
   end

   // Driver: one transfer, with step-level timing checks relative to acceptance
   task automatic xfer(input logic [1:0] sel, input logic [4:0] ra,
                       input logic [7:0] d, input bit stray);
      bit in_done;
      logic [1:0] exp_cs;
      while (busy_o) @(negedge clk);
      in_done = done_o;
      start_i = 1'b1; codec_sel_i = sel; reg_addr_i = ra; wr_data_i = d;
      exp_q.push_back({(sel != 0), 2'b10, 1'b1, ra, d});
      n_sent++;
      exp_cs = (sel != 0) ? 2'b01 : 2'b10;
      @(negedge clk);  // m = 0
      start_i = 1'b0;
      codec_sel_i = ~sel; reg_addr_i = ~ra; wr_data_i = ~d;  // R9: late changes ignored
      check(busy_o, "R8 busy after accept", busy_o, 1);
      if (in_done) check(busy_o, "R11 start in done cycle accepted", busy_o, 1);
      check(sclk_o && sdata_o && cs_n_o == 2'b11, "R4 pre-idle all high",
            {sclk_o, sdata_o, cs_n_o}, 4'hF);
      repeat (STEP) @(negedge clk);  // m = STEP
      check(cs_n_o == exp_cs && sclk_o, "R4 select setup step", {sclk_o, cs_n_o}, {1'b1, exp_cs});
      repeat (STEP) @(negedge clk);  // m = 2*STEP
      check(!sclk_o && cs_n_o == exp_cs, "R3 clock low first step", sclk_o, 0);
      repeat (STEP) @(negedge clk);  // m = 3*STEP
      check(sdata_o == 1'b1, "R2 first bit is MSB", sdata_o, 1);
      repeat (STEP) @(negedge clk);  // m = 4*STEP
      check(sclk_o, "R3 clock high third step", sclk_o, 0);
      if (stray) begin
         start_i = 1'b1; codec_sel_i = ~sel; reg_addr_i = ~ra; wr_data_i = ~d;
         @(negedge clk);
         start_i = 1'b0;
         repeat (46 * STEP - 1) @(negedge clk);
      end else begin
         repeat (46 * STEP) @(negedge clk);  // m = 50*STEP
      end
      check(busy_o && sclk_o && sdata_o && cs_n_o == 2'b11, "R6 post idle",
            {busy_o, sclk_o, sdata_o, cs_n_o}, 5'h1F);
      repeat (STEP - 1) @(negedge clk);
      check(!done_o && busy_o, "R7 not yet done", done_o, 0);
      @(negedge clk);  // m = 51*STEP
      check(done_o && !busy_o, "R7 R8 done timing", {done_o, busy_o}, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(sclk_o && sdata_o && cs_n_o == 2'b11 && !busy_o && !done_o,
            "R10 reset state", {sclk_o, sdata_o, cs_n_o, busy_o, done_o}, 6'h3C);
      rst = 1'b0;
      @(negedge clk);
      xfer(2'd0, 5'h03, 8'hA5, 0);
      xfer(2'd1, 5'h1F, 8'h00, 0);   // back-to-back in done cycle: R11
      xfer(2'd2, 5'h00, 8'hFF, 1);   // stray start while busy: R9
      xfer(2'd3, 5'h15, 8'h3C, 0);
      repeat (5) @(negedge clk);
      check(!done_o, "R8 done single pulse", done_o, 0);
      xfer(2'd0, 5'h0A, 8'h81, 1);
      repeat (3 * STEP) @(negedge clk);
      check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
      check(n_seen == n_sent, "R9 frame count", n_seen, n_sent);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule